// File: doc/BRIEF.md
# Two-Wire Bus Slave Port Expander

This block lets a host on a two-wire management bus reach eight output pins and eight input pins through one slave address. A write transfer moves each received byte straight onto the parallel output port. A read transfer returns the level of the parallel input port. There is no command byte and no register map. The host addresses the slave and then streams data bytes.

Both bus lines are oversampled by a local system clock through two-flop synchronizers and edge detectors. Start and stop conditions come from data-line edges seen while the bus clock is high. The slave never drives the data line high. It only asserts a pull-low enable, which the pad turns into an open-drain driver, and it watches the resolved line level on its input.

If the bus clock is held low longer than a configurable time (25 ms by default), the bus logic returns to idle and lets go of the data line.

Top module: `smb_gpio_expander`

## Requirements
- R1: After reset, `gpio_out` is 8'h00 and `sda_pull_low` is 0.
- R2: The first byte after a start holds the 7-bit address in bits 7..1, sent MSB first, and the direction in bit 0 (1 = read, 0 = write). When the address equals `SLAVE_ADDR` (default 7'h00), the slave pulls the data line low for the whole ninth clock.
- R3: When the address does not match, the slave does not acknowledge. It ignores all traffic, leaving `gpio_out` and the data line untouched, until the next start.
- R4: In a write, every data byte is received MSB first, placed on `gpio_out` and acknowledged. This repeats for any number of bytes.
- R5: `gpio_out` keeps its value while a byte is still being shifted in. It changes only once all eight bits have arrived.
- R6: In a read, `gpio_in` is sampled on the rising clock edge of the acknowledge bit. It is then shifted out MSB first, and later changes on `gpio_in` do not alter that byte.
- R7: In a read, a master ACK (data line low in the ninth clock) starts another byte with a fresh sample of `gpio_in`. A master NACK makes the slave release the line and stay silent until a stop or a start.
- R8: A stop returns the slave to idle. A repeated start, even in the middle of a byte, begins a new address phase.
- R9: The slave asserts `sda_pull_low` only while the bus clock is low, and has no way to drive the line high.
- R10: When the bus clock stays low for more than `TMO_US` microseconds, the slave goes idle and releases the data line. A byte clocked after that, without a new start, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Resolved data line level |
| sda_pull_low | output | 1 | 1 = pull the data line low, 0 = release |
| gpio_in | input | 8 | Parallel input port returned in reads |
| gpio_out | output | 8 | Parallel output port set by writes |

## Verification
The bench changes `gpio_in` right after the acknowledge edge. A slave that sampled late would return the new value instead of the one present at the acknowledge. A design that latched the partial shift register would move `gpio_out` in the middle of a byte. A missed NACK would keep the slave driving bits into what should be an idle bus. A repeated start issued after three data bits catches a bit counter that does not restart. The timeout is triggered while the slave is pulling the line low for its acknowledge, which exposes a slave that keeps holding the bus or keeps accepting bytes afterwards.

// File: rtl/smbx_pkg.sv
package smbx_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BITS,
        ST_WR_ACK,
        ST_RD_BITS,
        ST_RD_ACK,
        ST_HOLD
    } bus_st_e;

    typedef struct packed {
        bus_st_e               st;
        logic [BIT_CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0]     sh;
        logic                  rw;
        logic                  mack;
        logic                  drv;
        logic [BYTE_W-1:0]     gout;
    } ctl_s;
endpackage

// File: rtl/smbx_line_sync.sv
module smbx_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        // pipe[STAGES-1:0] is the synchronizer, pipe[STAGES] the previous level
        logic [STAGES:0] pipe_d, pipe_q;

        always_comb pipe_d = {pipe_q[STAGES-1:0], raw_i[g]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end

        assign level_o[g] = pipe_q[STAGES-1];
        assign rise_o[g]  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
        assign fall_o[g]  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end
endmodule

// File: rtl/smbx_low_timer.sv
module smbx_low_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (level_i)                   cnt_d = '0;
        else if (cnt_q != CW'(LIMIT))  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // one pulse per low period, the counter then saturates
    assign expire_o = !level_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/smb_gpio_expander.sv
module smb_gpio_expander
    import smbx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h00,
    parameter int unsigned       CLK_HZ     = 125_000_000,
    parameter int unsigned       TMO_US     = 25_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_low,
    input  logic [BYTE_W-1:0] gpio_in,
    output logic [BYTE_W-1:0] gpio_out
);
    localparam int unsigned         TMO_CYC  = (CLK_HZ / 1_000_000) * TMO_US;
    localparam logic [BIT_CNT_W-1:0] FULL_CNT = BIT_CNT_W'(BYTE_W);

    logic [1:0] lvl, rise, fall;
    logic       scl_s, sda_s, scl_up, scl_dn, start_ev, stop_ev, tmo;

    smbx_line_sync #(.LINES(2), .STAGES(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   ({sda_in, scl_in}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    smbx_low_timer #(.LIMIT(TMO_CYC)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (scl_s),
        .expire_o (tmo)
    );

    assign scl_s    = lvl[0];
    assign sda_s    = lvl[1];
    assign scl_up   = rise[0];
    assign scl_dn   = fall[0];
    assign start_ev = fall[1] & lvl[0];
    assign stop_ev  = rise[1] & lvl[0];

    ctl_s c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (tmo) begin
            c_d.st  = ST_IDLE;
            c_d.drv = 1'b0;
            c_d.cnt = '0;
        end else if (start_ev) begin
            c_d.st  = ST_ADDR;
            c_d.drv = 1'b0;
            c_d.cnt = '0;
        end else if (stop_ev) begin
            c_d.st  = ST_IDLE;
            c_d.drv = 1'b0;
            c_d.cnt = '0;
        end else begin
            unique case (c_q.st)
                ST_ADDR: begin
                    if (scl_up) begin
                        c_d.sh  = {c_q.sh[BYTE_W-2:0], sda_s};
                        c_d.cnt = c_q.cnt + 1'b1;
                    end else if (scl_dn && c_q.cnt == FULL_CNT) begin
                        c_d.cnt = '0;
                        if (c_q.sh[BYTE_W-1:1] == SLAVE_ADDR) begin
                            c_d.st  = ST_ADDR_ACK;
                            c_d.rw  = c_q.sh[0];
                            c_d.drv = 1'b1;
                        end else begin
                            c_d.st  = ST_HOLD;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_up && c_q.rw) begin
                        c_d.sh = gpio_in;
                    end else if (scl_dn) begin
                        if (c_q.rw) begin
                            c_d.st  = ST_RD_BITS;
                            c_d.drv = ~c_q.sh[BYTE_W-1];
                        end else begin
                            c_d.st  = ST_WR_BITS;
                            c_d.drv = 1'b0;
                        end
                    end
                end
                ST_WR_BITS: begin
                    if (scl_up) begin
                        c_d.sh  = {c_q.sh[BYTE_W-2:0], sda_s};
                        c_d.cnt = c_q.cnt + 1'b1;
                    end else if (scl_dn && c_q.cnt == FULL_CNT) begin
                        c_d.gout = c_q.sh;
                        c_d.drv  = 1'b1;
                        c_d.cnt  = '0;
                        c_d.st   = ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_dn) begin
                        c_d.drv = 1'b0;
                        c_d.st  = ST_WR_BITS;
                    end
                end
                ST_RD_BITS: begin
                    if (scl_up) begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end else if (scl_dn) begin
                        if (c_q.cnt == FULL_CNT) begin
                            c_d.drv = 1'b0;
                            c_d.cnt = '0;
                            c_d.st  = ST_RD_ACK;
                        end else begin
                            c_d.sh  = {c_q.sh[BYTE_W-2:0], 1'b0};
                            c_d.drv = ~c_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_up) begin
                        c_d.mack = ~sda_s;
                        if (!sda_s) c_d.sh = gpio_in;
                    end else if (scl_dn) begin
                        if (c_q.mack) begin
                            c_d.st  = ST_RD_BITS;
                            c_d.drv = ~c_q.sh[BYTE_W-1];
                        end else begin
                            c_d.st  = ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_pull_low = c_q.drv;
    assign gpio_out     = c_q.gout;

    // R9
    pull_while_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.drv) |-> !scl_s);

    // R5
    gpio_update_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c_q.gout) |-> c_q.drv);

    // R10
    timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> (c_q.st == ST_IDLE && !c_q.drv));

    // R7
    hold_is_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_HOLD) |-> !c_q.drv);

    // R2
    addr_ack_pulls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_ADDR_ACK) |-> c_q.drv);
endmodule

// File: tb/smb_gpio_expander_tb.sv
module smb_gpio_expander_tb_top;
    localparam int H       = 16;
    localparam int TMO_US  = 8;
    localparam int TMO_CYC = 125 * TMO_US;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pull_low;
    logic [7:0] gpio_in = 8'h00;
    logic [7:0] gpio_out;

    int n_chk = 0;
    int n_bad = 0;
    int r9_bad = 0;
    logic drv_prev = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull_low;

    smb_gpio_expander #(.SLAVE_ADDR(7'h00), .CLK_HZ(125_000_000), .TMO_US(TMO_US)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_m),
        .sda_in       (sda_line),
        .sda_pull_low (sda_pull_low),
        .gpio_in      (gpio_in),
        .gpio_out     (gpio_out)
    );

    // R9: a new pull-low must never appear while the master holds the clock high
    always @(negedge clk) begin
        if (rst_n && sda_pull_low && !drv_prev && scl_m) r9_bad++;
        drv_prev <= sda_pull_low;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        tick(H/2); sda_m = b; tick(H/2);
        scl_m = 1'b1; tick(H); scl_m = 1'b0;
    endtask

    task automatic bit_in(output logic v);
        tick(H/2); sda_m = 1'b1; tick(H/2);
        scl_m = 1'b1; tick(H/2); v = sda_line; tick(H/2); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl_m = 1'b0;
    endtask

    task automatic bus_rstart();
        tick(H/2); sda_m = 1'b1; tick(H/2);
        scl_m = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(H/2); sda_m = 1'b0; tick(H/2);
        scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic v;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(v);
        acked = !v;
    endtask

    task automatic read_bits(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
    endtask

    task automatic t_reset();
        chk("R1 gpio_out", gpio_out, 8'h00);
        chk("R1 pull", sda_pull_low, 1'b0);
    endtask

    task automatic t_write();
        logic a;
        bus_start();
        send_byte(8'h00, a);
        chk("R2 write addr ack", a, 1'b1);
        for (int i = 7; i >= 4; i--) bit_out(8'h5A >> i);
        chk("R5 mid-byte hold", gpio_out, 8'h00);
        for (int i = 3; i >= 0; i--) bit_out(8'h5A >> i);
        tick(6);
        chk("R5 update at byte end", gpio_out, 8'h5A);
        bit_in(a);
        chk("R4 data ack", !a, 1'b1);
        chk("R4 byte1", gpio_out, 8'h5A);
        send_byte(8'hC3, a);
        chk("R4 byte2 ack", a, 1'b1);
        chk("R4 byte2", gpio_out, 8'hC3);
        bus_stop();
        chk("R8 idle after stop", sda_pull_low, 1'b0);
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        send_byte(8'h22, a);
        chk("R3 no ack", a, 1'b0);
        send_byte(8'hFF, a);
        chk("R3 data not acked", a, 1'b0);
        chk("R3 gpio_out kept", gpio_out, 8'hC3);
        bus_stop();
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] v;
        gpio_in = 8'hA5;
        bus_start();
        send_byte(8'h01, a);
        chk("R2 read addr ack", a, 1'b1);
        gpio_in = 8'hFF;
        read_bits(v);
        chk("R6 sampled at ack", v, 8'hA5);
        gpio_in = 8'h3C;
        bit_out(1'b0);
        gpio_in = 8'h00;
        read_bits(v);
        chk("R7 fresh sample after ACK", v, 8'h3C);
        bit_out(1'b1);
        read_bits(v);
        chk("R7 silent after NACK", v, 8'hFF);
        bus_stop();
        chk("R7 gpio_out unchanged by read", gpio_out, 8'hC3);
    endtask

    task automatic t_rstart();
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(8'h00, a);
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
        bus_rstart();
        chk("R8 mid-byte rstart keeps out", gpio_out, 8'hC3);
        send_byte(8'h00, a);
        chk("R8 addr after rstart", a, 1'b1);
        send_byte(8'h42, a);
        chk("R8 write after rstart", gpio_out, 8'h42);
        gpio_in = 8'h6E;
        bus_rstart();
        send_byte(8'h01, a);
        chk("R8 read addr after rstart", a, 1'b1);
        read_bits(v);
        chk("R8 read after rstart", v, 8'h6E);
        bit_out(1'b1);
        bus_stop();
    endtask

    task automatic t_timeout();
        logic a;
        bus_start();
        for (int i = 7; i >= 0; i--) bit_out(1'b0);
        tick(6);
        chk("R2 pull during ack", sda_pull_low, 1'b1);
        tick(TMO_CYC + 100);
        chk("R10 released", sda_pull_low, 1'b0);
        send_byte(8'h00, a);
        chk("R10 byte ignored", a, 1'b0);
        chk("R10 gpio_out kept", gpio_out, 8'h42);
        bus_stop();
        bus_start();
        send_byte(8'h00, a);
        send_byte(8'h99, a);
        chk("R10 recovers", gpio_out, 8'h99);
        bus_stop();
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_write();
        t_wrong_addr();
        t_read();
        t_rstart();
        t_timeout();
        chk("R9 pull only with clock low", r9_bad, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule